// File: doc/BRIEF.md
# Counter Snapshot Capture Across Clock Domains

This block gives a fast bus domain a safe way to read a 32-bit free-running count that ticks in a slow, unrelated clock domain. Bus logic never samples the live count, because it could catch it mid-transition. Instead, a bus write with bit 0 set starts a capture. The request travels into the counter domain as a toggle through a synchronizer. On the first counter-clock edge that sees the request, the count is frozen into a holding register, and an acknowledge toggle travels back.

When the synchronized acknowledge reaches the bus domain, the frozen value is copied into the readable snapshot register in a single cycle and the valid flag is raised. A request written while a capture is still in flight is merged into that capture and is not queued. Software requests a snapshot, reads the capture register a few times to let the handshake finish, and uses the last value once the valid flag is set.

Top module: `cnt_snap_reader`

## Requirements
- R1: After reset, `snap_rdata` is 0 and `snap_valid` is 0.
- R2: A bus write (`cap_wr_en` high) with `cap_wr_data[0]` = 1 clears `snap_valid` on the next `bus_clk` edge and starts a capture.
- R3: A bus write with `cap_wr_data[0]` = 0 has no effect. `snap_valid` and `snap_rdata` keep their values regardless of the other data bits.
- R4: A completed snapshot equals a counter value that lies between the count seen when the request was written and the count seen when `snap_valid` sets, compared modulo 2^32, so it stays correct across the counter wrap.
- R5: With two-stage synchronizers, `snap_valid` sets no later than 4 counter-clock periods plus 4 bus cycles after the requesting write.
- R6: While a capture is outstanding, `snap_rdata` keeps the previous snapshot. It changes only in the cycle the acknowledge completes a capture.
- R7: A request written while a capture is outstanding starts no second capture. The pending capture completes once, and `snap_valid` is never high while a capture is outstanding.
- R8: The counter-domain holding register changes only on the edge that also flips the acknowledge toggle, so the bus domain copies a value that is stable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Bus-domain clock |
| bus_rst | input | 1 | Synchronous active-high reset, bus domain |
| cap_wr_en | input | 1 | Write strobe for the capture register |
| cap_wr_data | input | 32 | Write data. Bit 0 set requests a snapshot |
| snap_rdata | output | 32 | Last completed snapshot (capture register read value) |
| snap_valid | output | 1 | High when `snap_rdata` holds the result of the latest request |
| cnt_clk | input | 1 | Counter-domain clock, slow and unrelated to `bus_clk` |
| cnt_rst | input | 1 | Synchronous active-high reset, counter domain |
| cnt_value | input | 32 | Live count, changing on `cnt_clk` |

## Verification
A lost or duplicated request toggle shows at the ports as `snap_valid` staying low past the latency bound of a few counter periods, or rising a second time after a merged request. If the holding register is sampled at the wrong moment, or copied before the acknowledge arrives, the snapshot falls outside the window of counts seen between request and completion. That is visible in the first completion that follows. A wrong decode of the write data shows in the same cycle as a dropped `snap_valid` or a changed `snap_rdata`.

// File: rtl/cnt_snap_pkg.sv
`timescale 1ns/1ps
package cnt_snap_pkg;

    localparam int SNAP_W_DEF      = 32;
    localparam int SYNC_STAGES_DEF = 2;

    // Bus-domain control state of the capture handshake.
    typedef struct packed {
        logic req_tgl;   // flips once per launched capture
        logic pending;   // capture outstanding
        logic valid;     // snapshot register current
    } bus_ctl_t;

    localparam bus_ctl_t BUS_CTL_RST = '{req_tgl: 1'b0, pending: 1'b0, valid: 1'b0};

    // A toggle edge is seen when the synchronized level differs from the
    // last level consumed.
    function automatic logic tgl_event(input logic synced, input logic seen);
        return synced ^ seen;
    endfunction

endpackage

// File: rtl/cnt_snap_sync.sv
`timescale 1ns/1ps
module cnt_snap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= d_async;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], d_async};
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/cnt_snap_cnt_side.sv
`timescale 1ns/1ps
module cnt_snap_cnt_side
    import cnt_snap_pkg::*;
#(
    parameter int SNAP_W      = SNAP_W_DEF,
    parameter int SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic              cnt_clk,
    input  logic              cnt_rst,
    input  logic              req_tgl_async,
    input  logic [SNAP_W-1:0] cnt_value,
    output logic [SNAP_W-1:0] hold_q,
    output logic              ack_tgl
);
    logic req_sync;
    logic req_seen_q;
    logic take;

    cnt_snap_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk     (cnt_clk),
        .rst     (cnt_rst),
        .d_async (req_tgl_async),
        .q       (req_sync)
    );

    assign take = tgl_event(req_sync, req_seen_q);

    // Freeze the count and answer on the same edge, so the value is
    // settled before the acknowledge can be seen on the bus side.
    always_ff @(posedge cnt_clk) begin
        if (cnt_rst) begin
            hold_q     <= '0;
            ack_tgl    <= 1'b0;
            req_seen_q <= 1'b0;
        end else if (take) begin
            hold_q     <= cnt_value;
            ack_tgl    <= ~ack_tgl;
            req_seen_q <= req_sync;
        end
    end
endmodule

// File: rtl/cnt_snap_bus_side.sv
`timescale 1ns/1ps
module cnt_snap_bus_side
    import cnt_snap_pkg::*;
#(
    parameter int SNAP_W      = SNAP_W_DEF,
    parameter int SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic              bus_clk,
    input  logic              bus_rst,
    input  logic              start_req,
    input  logic              ack_tgl_async,
    input  logic [SNAP_W-1:0] hold_async,
    output logic              req_tgl,
    output logic              pending,
    output logic              valid,
    output logic [SNAP_W-1:0] snap_q
);
    bus_ctl_t ctl_q, ctl_d;
    logic     ack_sync;
    logic     ack_seen_q;
    logic     done;

    cnt_snap_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk     (bus_clk),
        .rst     (bus_rst),
        .d_async (ack_tgl_async),
        .q       (ack_sync)
    );

    assign done = tgl_event(ack_sync, ack_seen_q);

    always_comb begin
        ctl_d = ctl_q;
        if (done) begin
            ctl_d.pending = 1'b0;
            ctl_d.valid   = 1'b1;
        end
        if (start_req) begin
            // Launch only when nothing is in flight (or it ends now);
            // otherwise the request folds into the outstanding capture.
            if (!ctl_q.pending || done) ctl_d.req_tgl = ~ctl_q.req_tgl;
            ctl_d.pending = 1'b1;
            ctl_d.valid   = 1'b0;
        end
    end

    always_ff @(posedge bus_clk) begin
        if (bus_rst) begin
            ctl_q      <= BUS_CTL_RST;
            ack_seen_q <= 1'b0;
            snap_q     <= '0;
        end else begin
            ctl_q <= ctl_d;
            if (done) begin
                ack_seen_q <= ack_sync;
                snap_q     <= hold_async;
            end
        end
    end

    assign req_tgl = ctl_q.req_tgl;
    assign pending = ctl_q.pending;
    assign valid   = ctl_q.valid;
endmodule

// File: rtl/cnt_snap_reader.sv
`timescale 1ns/1ps
module cnt_snap_reader
    import cnt_snap_pkg::*;
#(
    parameter int SNAP_W      = SNAP_W_DEF,
    parameter int SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic              bus_clk,
    input  logic              bus_rst,
    input  logic              cap_wr_en,
    input  logic [SNAP_W-1:0] cap_wr_data,
    output logic [SNAP_W-1:0] snap_rdata,
    output logic              snap_valid,
    input  logic              cnt_clk,
    input  logic              cnt_rst,
    input  logic [SNAP_W-1:0] cnt_value
);
    logic              start_req;
    logic              req_tgl;
    logic              ack_tgl;
    logic              req_pending;
    logic [SNAP_W-1:0] hold_val;

    assign start_req = cap_wr_en & cap_wr_data[0];

    cnt_snap_bus_side #(.SNAP_W(SNAP_W), .SYNC_STAGES(SYNC_STAGES)) u_bus (
        .bus_clk       (bus_clk),
        .bus_rst       (bus_rst),
        .start_req     (start_req),
        .ack_tgl_async (ack_tgl),
        .hold_async    (hold_val),
        .req_tgl       (req_tgl),
        .pending       (req_pending),
        .valid         (snap_valid),
        .snap_q        (snap_rdata)
    );

    cnt_snap_cnt_side #(.SNAP_W(SNAP_W), .SYNC_STAGES(SYNC_STAGES)) u_cnt (
        .cnt_clk       (cnt_clk),
        .cnt_rst       (cnt_rst),
        .req_tgl_async (req_tgl),
        .cnt_value     (cnt_value),
        .hold_q        (hold_val),
        .ack_tgl       (ack_tgl)
    );
endmodule

// File: rtl/cnt_snap_checker.sv
`timescale 1ns/1ps
module cnt_snap_checker #(
    parameter int SNAP_W = 32
) (
    input logic              bus_clk,
    input logic              bus_rst,
    input logic              cap_wr_en,
    input logic [SNAP_W-1:0] cap_wr_data,
    input logic [SNAP_W-1:0] snap_rdata,
    input logic              snap_valid,
    input logic              req_pending,
    input logic              cnt_clk,
    input logic              cnt_rst,
    input logic [SNAP_W-1:0] hold_val,
    input logic              ack_tgl
);
    // R2
    a_r2_request_clears_valid: assert property (@(posedge bus_clk) disable iff (bus_rst)
        (cap_wr_en && cap_wr_data[0]) |=> (!snap_valid && req_pending));

    // R3
    a_r3_zero_write_ignored: assert property (@(posedge bus_clk) disable iff (bus_rst)
        (cap_wr_en && !cap_wr_data[0] && snap_valid) |=> (snap_valid && $stable(snap_rdata)));

    // R6
    a_r6_data_moves_on_completion: assert property (@(posedge bus_clk) disable iff (bus_rst)
        !$stable(snap_rdata) |-> $past(req_pending));

    // R7
    a_r7_valid_after_request: assert property (@(posedge bus_clk) disable iff (bus_rst)
        $rose(snap_valid) |-> $past(req_pending));

    // R7
    a_r7_valid_excludes_pending: assert property (@(posedge bus_clk) disable iff (bus_rst)
        !(snap_valid && req_pending));

    // R8
    a_r8_hold_moves_with_ack: assert property (@(posedge cnt_clk) disable iff (cnt_rst)
        !$stable(hold_val) |-> (ack_tgl != $past(ack_tgl)));
endmodule

bind cnt_snap_reader cnt_snap_checker #(.SNAP_W(SNAP_W)) u_chk (
    .bus_clk     (bus_clk),
    .bus_rst     (bus_rst),
    .cap_wr_en   (cap_wr_en),
    .cap_wr_data (cap_wr_data),
    .snap_rdata  (snap_rdata),
    .snap_valid  (snap_valid),
    .req_pending (req_pending),
    .cnt_clk     (cnt_clk),
    .cnt_rst     (cnt_rst),
    .hold_val    (hold_val),
    .ack_tgl     (ack_tgl)
);

// File: tb/cnt_snap_reader_test.sv
`timescale 1ns/1ps
module cnt_snap_reader_test;

    localparam int    W        = 32;
    localparam real   BUS_HALF = 10.0;   // 50 MHz
    localparam real   CNT_HALF = 36.5;   // 73 ns, non-integer ratio to the bus
    localparam int    LAT_MAX  = 19;     // ceil(4*73/20) + 4 bus cycles
    localparam int    WAIT_CAP = 80;

    logic         bus_clk = 1'b0;
    logic         cnt_clk = 1'b0;
    logic         bus_rst = 1'b1;
    logic         cnt_rst = 1'b1;
    logic         cap_wr_en = 1'b0;
    logic [W-1:0] cap_wr_data = '0;
    logic [W-1:0] snap_rdata;
    logic         snap_valid;
    logic [W-1:0] cnt_model = 32'hFFFF_FFF0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit saw_high = 0;
    bit saw_wrapped = 0;

    cnt_snap_reader uut (
        .bus_clk     (bus_clk),
        .bus_rst     (bus_rst),
        .cap_wr_en   (cap_wr_en),
        .cap_wr_data (cap_wr_data),
        .snap_rdata  (snap_rdata),
        .snap_valid  (snap_valid),
        .cnt_clk     (cnt_clk),
        .cnt_rst     (cnt_rst),
        .cnt_value   (cnt_model)
    );

    always #(BUS_HALF) bus_clk = ~bus_clk;
    always #(CNT_HALF) cnt_clk = ~cnt_clk;
    always @(posedge cnt_clk) cnt_model <= cnt_model + 1;

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge bus_clk) begin
        cycles <= cycles + 1;
        if (cycles > 60000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected below 60000", cycles);
            finish_run();
        end
    end

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [W-1:0] data, output logic [W-1:0] cnt_at);
        @(negedge bus_clk);
        cap_wr_en   = 1'b1;
        cap_wr_data = data;
        cnt_at      = cnt_model;
        @(negedge bus_clk);
        cap_wr_en   = 1'b0;
        cap_wr_data = '0;
    endtask

    // Waits for completion; checks latency (R5), the held old value (R6)
    // and the count window (R4).
    task automatic await_snapshot(input logic [W-1:0] lo, input logic [W-1:0] old_snap,
                                  output logic [W-1:0] got);
        int n = 1;
        logic [W-1:0] hi;
        bit held_ok = 1;
        while (!snap_valid && n < WAIT_CAP) begin
            if (snap_rdata !== old_snap) held_ok = 0;
            @(negedge bus_clk);
            n++;
        end
        hi  = cnt_model;
        got = snap_rdata;
        check("R6 old value held while pending", {31'd0, held_ok}, 32'd1);
        checks++;
        if (n > LAT_MAX) begin
            errors++;
            $display("FAIL R5 latency: actual %0d cycles expected <= %0d", n, LAT_MAX);
        end
        checks++;
        if ((got - lo) > (hi - lo)) begin
            errors++;
            $display("FAIL R4 window: actual %h expected within %h..%h", got, lo, hi);
        end
        if (got >= 32'hFFFF_FFF0) saw_high = 1;
        if (saw_high && got < 32'h0000_0100) saw_wrapped = 1;
    endtask

    initial begin
        logic [W-1:0] lo, lo2, prev, got, kept;
        repeat (6) @(negedge bus_clk);
        bus_rst = 1'b0;
        cnt_rst = 1'b0;
        @(negedge bus_clk);
        check("R1 reset data", snap_rdata, '0);
        check("R1 reset valid", {31'd0, snap_valid}, 32'd0);

        // Sweep of request timings against the counter phase.
        prev = '0;
        for (int i = 0; i < 24; i++) begin
            repeat (i % 7) @(negedge bus_clk);
            #((i % 3) * 7);
            bus_write(32'h1 | (i << 4), lo);
            check("R2 valid cleared", {31'd0, snap_valid}, 32'd0);
            await_snapshot(lo, prev, got);
            check("R2 valid set", {31'd0, snap_valid}, 32'd1);
            prev = got;
        end
        check("R4 wrap seen", {31'd0, saw_wrapped}, 32'd1);

        // Writes with bit 0 clear leave everything as it was.
        kept = snap_rdata;
        bus_write(32'hFFFF_FFFE, lo);
        check("R3 valid kept", {31'd0, snap_valid}, 32'd1);
        check("R3 data kept", snap_rdata, kept);
        repeat (40) @(negedge bus_clk);
        check("R3 valid kept later", {31'd0, snap_valid}, 32'd1);
        check("R3 data kept later", snap_rdata, kept);

        // Request while pending is merged into the outstanding capture.
        bus_write(32'h3, lo);
        bus_write(32'h1, lo2);
        check("R7 valid low after merge", {31'd0, snap_valid}, 32'd0);
        await_snapshot(lo, kept, got);
        check("R7 merged capture done", {31'd0, snap_valid}, 32'd1);
        begin
            bit stayed = 1;
            for (int k = 0; k < 40; k++) begin
                @(negedge bus_clk);
                if (!snap_valid || snap_rdata !== got) stayed = 0;
            end
            check("R7 no second capture", {31'd0, stayed}, 32'd1);
        end

        // Back-to-back after completion still works.
        bus_write(32'h1, lo);
        check("R2 valid cleared again", {31'd0, snap_valid}, 32'd0);
        await_snapshot(lo, got, got);

        finish_run();
    end
endmodule